// File: doc/BRIEF.md
# HDLC Transmit Framer with 64k/56k Octet Packing

This block turns a byte-stream frame into the HDLC line bits for one B-channel and packs those bits into octets for a sample stream. Each frame is sent in order as an opening flag, the payload with zero-bit insertion, a 16-bit frame check sequence, and a closing flag. When the last octet of a frame is only partly filled, the block completes it with ones and then appends one all-ones octet. When no frame is in progress, the output carries all-ones idle octets.

A mode input chooses how the bits are packed. In the 64 kbit/s packing, each octet carries eight line bits. In the 56 kbit/s packing, each octet carries seven line bits and its top bit is forced high. The mode is captured at the start of each frame.

The payload arrives on a valid/ready byte port that has a last-byte marker. The octets leave on a valid/ready port. The block sends one line bit per clock, so a fast upstream source is stalled by the bit rate and by the downstream ready.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted, and whenever no frame is in progress, `outValid` is 1 and `outData` is 0xFF. `inReady` is 0 while reset is asserted and while the block is idle.
- R2: In 64k packing, the first octet of every frame is the flag 0x7E, aligned to a whole octet.
- R3: Payload bytes are sent least significant bit first. Line bits fill each octet starting at bit 0 and moving upward, so the first bit sent is in bit 0.
- R4: Within the payload and the check sequence, a 0 is inserted after every run of five consecutive 1 bits, and the run count then restarts.
- R5: The check sequence is CRC-16 computed with the reflected polynomial 0x8408, starting from 0xFFFF, and complemented at the end. It is sent low byte first and is subject to the zero insertion of R4.
- R6: The closing flag 0x7E follows the check sequence directly and receives no zero insertion.
- R7: If the closing flag does not end on an octet boundary, the remaining bit positions of that octet are set to 1, and one extra 0xFF octet follows it.
- R8: In 56k packing (`mode56k` = 1), each octet holds seven line bits in bits 6:0, with the first bit in bit 0, and bit 7 is 1. The opening flag is packed the same way.
- R9: The mode is sampled only when a frame starts. Changing `mode56k` during a frame has no effect on that frame.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` does not change.
- R11: The zero-insertion run counter and the octet bit position restart at each frame. A frame sent directly after another frame encodes exactly as it would after an idle gap.
- R12: `inReady` is high only while the block waits for the next payload byte. After a byte is accepted, `inReady` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode56k | input | 1 | 1 selects 7-bit (56k) packing, 0 selects 8-bit (64k) packing; sampled at frame start |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte valid; when high in idle, it also requests a new frame |
| inLast | input | 1 | Marks the final payload byte of the frame |
| inReady | output | 1 | Payload byte accepted at this edge when `inValid` is also high |
| outData | output | 8 | Packed line octet |
| outValid | output | 1 | Octet valid |
| outReady | input | 1 | Downstream accepts the octet |

## Verification
The assertions take the following for granted about the inputs:
- Every frame has at least one byte, and only its final byte carries `inLast`.
- `inValid` and `inData` stay steady until the block accepts the byte.
- A frame whose `inValid` is raised while another frame is still being sent only starts once the block returns to idle.

The stimulus keeps within these rules by driving bytes from a task that holds them until it sees `inReady`. Frames are either queued straight behind the previous one or separated by idle gaps. The mode input changes only between byte handshakes, including the deliberate change in the middle of a frame. `outReady` is sometimes tied high and sometimes driven from a pseudo-random pattern, so that octets are held under backpressure.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int          OCT_W     = 8;
  localparam int          FCS_W     = 16;
  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam logic [7:0]  IDLE_PAT  = 8'hFF;
  localparam logic [15:0] CRC_POLY  = 16'h8408;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;

  // strobes from the sequencer to the octet assembler
  typedef struct packed {
    logic shift;        // one line bit presented this cycle
    logic bitVal;       // its value
    logic frameActive;  // a frame is in progress
    logic mode56;       // latched packing mode of the current frame
    logic stuffZone;    // bit belongs to the zero-insertion region
  } txStrobes_t;

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int RUN_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic [OCT_W-1:0] inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             spaceOk,
  input  logic             aligned,
  output txStrobes_t       strb
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam int IDX_W = $clog2(FCS_W);
  localparam logic [IDX_W-1:0] OCT_LAST  = IDX_W'(OCT_W - 1);
  localparam logic [IDX_W-1:0] PACK_LAST = IDX_W'(OCT_W - 2);
  localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(FCS_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(RUN_LIMIT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_LOAD, ST_DATA, ST_FCS, ST_CLOSE, ST_PAD, ST_EXTRA
  } txState_e;

  txState_e         state;
  logic [IDX_W-1:0] bitIdx;
  logic [OCT_W-1:0] curByte;
  logic             lastByte;
  logic [15:0]      crcAcc;
  logic [15:0]      fcsSh;
  logic [RUN_W-1:0] runCnt;
  logic             padded;
  logic             modeLat;

  logic stuffNow, bitOut, emit, inZone;
  logic [IDX_W-1:0] extraLast;

  assign inZone    = (state == ST_DATA) || (state == ST_FCS);
  assign stuffNow  = (runCnt == RUN_MAX) && (inZone || state == ST_CLOSE);
  assign extraLast = modeLat ? PACK_LAST : OCT_LAST;

  always_comb begin
    case (state)
      ST_OPEN:  bitOut = FLAG_PAT[bitIdx[2:0]];
      ST_DATA:  bitOut = curByte[bitIdx[2:0]];
      ST_FCS:   bitOut = fcsSh[bitIdx];
      ST_CLOSE: bitOut = FLAG_PAT[bitIdx[2:0]];
      default:  bitOut = 1'b1;
    endcase
    if (stuffNow) bitOut = 1'b0;
  end

  always_comb begin
    case (state)
      ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_EXTRA: emit = spaceOk;
      ST_PAD:  emit = spaceOk && !aligned;
      default: emit = 1'b0;
    endcase
  end

  assign inReady          = (state == ST_LOAD);
  assign strb.shift       = emit;
  assign strb.bitVal      = bitOut;
  assign strb.frameActive = (state != ST_IDLE);
  assign strb.mode56      = modeLat;
  assign strb.stuffZone   = inZone || stuffNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      curByte  <= '0;
      lastByte <= 1'b0;
      crcAcc   <= CRC_INIT;
      fcsSh    <= '0;
      runCnt   <= '0;
      padded   <= 1'b0;
      modeLat  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_OPEN;
          modeLat <= modeSel;
          bitIdx  <= '0;
          runCnt  <= '0;
          crcAcc  <= CRC_INIT;
          padded  <= 1'b0;
        end
        ST_OPEN: if (emit) begin
          if (bitIdx == OCT_LAST) begin
            state  <= ST_LOAD;
            bitIdx <= '0;
          end else bitIdx <= bitIdx + 1'b1;
        end
        ST_LOAD: if (inValid) begin
          curByte  <= inData;
          lastByte <= inLast;
          crcAcc   <= crcByte(crcAcc, inData);
          state    <= ST_DATA;
          bitIdx   <= '0;
        end
        ST_DATA: if (emit) begin
          if (stuffNow) runCnt <= '0;
          else begin
            runCnt <= bitOut ? runCnt + 1'b1 : '0;
            if (bitIdx == OCT_LAST) begin
              bitIdx <= '0;
              if (lastByte) begin
                state <= ST_FCS;
                fcsSh <= ~crcAcc;
              end else state <= ST_LOAD;
            end else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_FCS: if (emit) begin
          if (stuffNow) runCnt <= '0;
          else begin
            runCnt <= bitOut ? runCnt + 1'b1 : '0;
            if (bitIdx == FCS_LAST) begin
              bitIdx <= '0;
              state  <= ST_CLOSE;
            end else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_CLOSE: if (emit) begin
          runCnt <= '0;
          if (!stuffNow) begin
            if (bitIdx == OCT_LAST) begin
              bitIdx <= '0;
              state  <= ST_PAD;
            end else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_PAD: begin
          if (aligned) begin
            state  <= padded ? ST_EXTRA : ST_IDLE;
            bitIdx <= '0;
          end else if (emit) padded <= 1'b1;
        end
        ST_EXTRA: if (emit) begin
          if (bitIdx == extraLast) begin
            state  <= ST_IDLE;
            bitIdx <= '0;
          end else bitIdx <= bitIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdlc_tx_dpath.sv
module hdlc_tx_dpath
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  txStrobes_t       strb,
  input  logic             outReady,
  output logic [OCT_W-1:0] outData,
  output logic             outValid,
  output logic             spaceOk,
  output logic             aligned,
  output logic             octDone
);

  localparam int CNT_W = $clog2(OCT_W + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OCT_W - 1);
  localparam logic [CNT_W-1:0] PACK_LAST = CNT_W'(OCT_W - 2);

  logic [CNT_W-1:0] fillCnt;
  logic [OCT_W-1:0] shReg;
  logic [OCT_W-1:0] nextSh;
  logic [OCT_W-1:0] octet;
  logic [CNT_W-1:0] lastSlot;
  logic             atLast;

  assign lastSlot = strb.mode56 ? PACK_LAST : FULL_LAST;
  assign atLast   = (fillCnt == lastSlot);
  assign spaceOk  = !atLast || !outValid || outReady;
  assign aligned  = (fillCnt == '0);
  assign octDone  = strb.shift && atLast;
  assign nextSh   = {strb.bitVal, shReg[OCT_W-1:1]};

  // 56k packing drops the oldest slot and forces the top bit high
  generate
    for (genvar k = 0; k < OCT_W; k++) begin : g_pack
      if (k == OCT_W - 1) begin : g_top
        assign octet[k] = strb.mode56 ? 1'b1 : nextSh[k];
      end else begin : g_low
        assign octet[k] = strb.mode56 ? nextSh[k+1] : nextSh[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      shReg    <= '0;
      outData  <= IDLE_PAT;
      outValid <= 1'b1;
    end else begin
      if (strb.shift) begin
        shReg   <= nextSh;
        fillCnt <= atLast ? '0 : fillCnt + 1'b1;
      end
      if (octDone) begin
        outData  <= octet;
        outValid <= 1'b1;
      end else if (!outValid || outReady) begin
        if (!strb.frameActive) begin
          outData  <= IDLE_PAT;
          outValid <= 1'b1;
        end else begin
          outValid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mode56k,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady
);

  txStrobes_t ctlStrb;
  logic       spaceOk;
  logic       aligned;
  logic       octDone;

  hdlc_tx_ctrl #(.RUN_LIMIT(5)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (mode56k),
    .inData  (inData),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .spaceOk (spaceOk),
    .aligned (aligned),
    .strb    (ctlStrb)
  );

  hdlc_tx_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (ctlStrb),
    .outReady (outReady),
    .outData  (outData),
    .outValid (outValid),
    .spaceOk  (spaceOk),
    .aligned  (aligned),
    .octDone  (octDone)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
  import hdlc_tx_pkg::*;
#(
  parameter int RUN_LIMIT = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input txStrobes_t strb,
  input logic       octDone
);

  logic [3:0] onesRun;

  always_ff @(posedge clk) begin
    if (!rstN) onesRun <= '0;
    else if (strb.shift) begin
      if (strb.stuffZone && strb.bitVal) onesRun <= (onesRun == 4'hF) ? onesRun : onesRun + 1'b1;
      else                               onesRun <= '0;
    end
  end

  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  p_one_byte_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

  p_msb_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    octDone && strb.mode56 |=> outData[7]);

  p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift && strb.stuffZone && (onesRun == 4'(RUN_LIMIT)) |-> !strb.bitVal);

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameActive |=> (!strb.frameActive || $stable(strb.mode56)));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_LIMIT(5)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .strb     (ctlStrb),
  .octDone  (octDone)
);

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       mode56k;
  logic [7:0] inData;
  logic       inValid;
  logic       inLast;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  randReady = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  int         lenQ[$];
  bit         inFrm = 1'b0;
  int         left = 0;
  bit         prevHold = 1'b0;
  logic [7:0] prevData = 8'h00;

  always #4 clk = ~clk;

  hdlc_tx_framer u_dut (
    .clk(clk), .rstN(rstN), .mode56k(mode56k), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady)
  );

  // reference model: line bits built behaviourally, then packed into octets
  task automatic buildFrame(input logic [7:0] d[$], input bit m56, input string tag);
    bit          bits[$];
    int          run;
    logic [15:0] c;
    logic [15:0] fcs;
    logic [7:0]  oct;
    int          w, idx, cnt, got;
    bit          partial;
    run = 0;
    c = 16'hFFFF;
    for (int i = 0; i < 8; i++) bits.push_back(((8'h7E >> i) & 1) != 0);
    foreach (d[k]) begin
      for (int i = 0; i < 8; i++) begin
        bit b;
        b = d[k][i];
        if (c[0] ^ b) c = (c >> 1) ^ 16'h8408; else c = c >> 1;
        bits.push_back(b);
        if (b) run++; else run = 0;
        if (run == 5) begin bits.push_back(1'b0); run = 0; end
      end
    end
    fcs = ~c;
    for (int i = 0; i < 16; i++) begin
      bit b;
      b = fcs[i];
      bits.push_back(b);
      if (b) run++; else run = 0;
      if (run == 5) begin bits.push_back(1'b0); run = 0; end
    end
    for (int i = 0; i < 8; i++) bits.push_back(((8'h7E >> i) & 1) != 0);
    w = m56 ? 7 : 8;
    idx = 0;
    cnt = 0;
    partial = 1'b0;
    while (idx < bits.size()) begin
      oct = 8'hFF;
      got = 0;
      for (int k = 0; k < w; k++) begin
        if (idx < bits.size()) begin oct[k] = bits[idx]; idx++; got++; end
      end
      if (got < w) partial = 1'b1;
      expQ.push_back(oct); tagQ.push_back(tag); cnt++;
    end
    if (partial) begin expQ.push_back(8'hFF); tagQ.push_back(tag); cnt++; end
    lenQ.push_back(cnt);
  endtask

  task automatic sendFrame(input logic [7:0] d[$], input bit m56, input string tag, input bit flip);
    buildFrame(d, m56, tag);
    mode56k = m56;
    foreach (d[k]) begin
      inData  = d[k];
      inLast  = (k == d.size() - 1);
      inValid = 1'b1;
      forever begin
        @(negedge clk);
        if (inReady) break;
      end
      @(posedge clk);
      #1;
      if (flip && k == 0) mode56k = !m56;
      @(negedge clk);
      checks++;
      if (inReady) begin
        failures++;
        $display("FAIL R12 %s: inReady actual=%0b expected=0 after byte accept", tag, inReady);
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    outReady = randReady ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (prevHold) begin
        checks++;
        if (outValid !== 1'b1 || outData !== prevData) begin
          failures++;
          $display("FAIL R10: held octet actual=%0b/%02h expected=1/%02h", outValid, outData, prevData);
        end
      end
      prevHold = outValid && !outReady;
      prevData = outData;
      if (outValid && outReady) begin
        if (!inFrm && outData != 8'hFF && lenQ.size() > 0) begin
          inFrm = 1'b1;
          left = lenQ.pop_front();
        end
        if (inFrm) begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (outData !== e) begin
            failures++;
            $display("FAIL %s: octet actual=%02h expected=%02h", t, outData, e);
          end
          left--;
          if (left == 0) inFrm = 1'b0;
        end else if (lenQ.size() == 0) begin
          checks++;
          if (outData !== 8'hFF) begin
            failures++;
            $display("FAIL R1: idle octet actual=%02h expected=ff", outData);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=drained");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] fr[$];
    rstN = 1'b0; mode56k = 1'b0; inData = 8'h00; inValid = 1'b0; inLast = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b1 || outData !== 8'hFF || inReady !== 1'b0) begin
      failures++;
      $display("FAIL R1: reset actual=%0b/%02h/%0b expected=1/ff/0", outValid, outData, inReady);
    end
    @(posedge clk); #1 rstN = 1'b1;
    repeat (20) @(posedge clk); #1;

    fr = {8'h01, 8'h02, 8'h03};
    sendFrame(fr, 1'b0, "R2 R3 R5 R6 R7", 1'b0);
    repeat (60) @(posedge clk); #1;
    fr = {8'hFF, 8'hFF, 8'hFF, 8'h7E};
    sendFrame(fr, 1'b0, "R4 R5", 1'b0);
    repeat (60) @(posedge clk); #1;
    fr = {8'h12, 8'h34, 8'hAB, 8'hCD, 8'hEF};
    sendFrame(fr, 1'b1, "R8 R3", 1'b0);
    repeat (60) @(posedge clk); #1;
    fr = {8'h55, 8'hAA, 8'h0F};
    sendFrame(fr, 1'b0, "R9", 1'b1);
    repeat (60) @(posedge clk); #1;
    fr = {8'hF8, 8'h1F};
    sendFrame(fr, 1'b1, "R11 first", 1'b0);
    fr = {8'h3C};
    sendFrame(fr, 1'b0, "R11 second", 1'b0);
    repeat (60) @(posedge clk); #1;
    randReady = 1'b1;
    fr = {8'hC3, 8'hFF, 8'h00, 8'h81, 8'h7E};
    sendFrame(fr, 1'b0, "R10 R7", 1'b0);
    fr = {8'hFF, 8'hFF};
    sendFrame(fr, 1'b1, "R10 R8", 1'b0);
    repeat (200) @(posedge clk); #1;
    randReady = 1'b0;
    while (lenQ.size() != 0 || inFrm) @(posedge clk);
    repeat (40) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule